// File: doc/BRIEF.md
# Merging Write Buffer with Read Forwarding

This block sits between a write-through data cache and a slower memory port. It takes each store, which carries one 8-byte word, and keeps it so that the processor does not wait on memory. Every entry covers one aligned block of four words and holds a valid bit for each word. A store to a block that is already buffered, and not yet being written out, goes into that entry's word slot. It does not use a new entry. The oldest entry is written to memory as one transaction. That transaction carries the block address, all four word lanes and the mask of valid words.

A read that missed in the cache looks up the buffer in the same cycle. The parameter `FORWARD` selects how it behaves. With forwarding on, the read returns the newest buffered copy of the word. A store accepted in the same cycle counts as the newest copy. With forwarding off, the read is told to stall until the buffer is empty, and the buffer starts draining at once.

An entry is not offered to memory as soon as it is allocated. The head entry is held back so that later stores can merge into it. It is offered when any of these is true: a second entry exists, all of its words are valid, it has waited `HOLD` cycles, or a read is stalling on it. Once offered, the entry is closed to merges.

Top module: `wbuf_merge_top`

## Requirements
- R1: After a synchronous active-low reset, the buffer is empty. `mem_valid` is 0, `st_ready` is 1, `rd_hit` is 0 and `rd_stall` is 0.
- R2: A store whose block address (address bits 31..5) equals that of a buffered entry not being offered takes no new entry. It writes the word selected by address bits 4..3 and sets that word's mask bit. Stores to byte addresses 100, 108, 116 and 124 leave a single entry with mask 4'b1111.
- R3: A store that matches no open entry allocates an entry at the tail. The new entry's mask has only the stored word's bit set, and its other data lanes are zero.
- R4: When all `DEPTH` entries are in use and a store matches no open entry, `st_ready` is 0 and the store is not taken.
- R5: Entries leave in allocation order, one per handshake (`mem_valid` and `mem_ready` both high). `mem_addr` is the block's byte address with bits 4..0 zero. Word w travels on `mem_data[64w+63:64w]` with mask bit w. While `mem_valid` is high and `mem_ready` is low, all offered fields hold steady.
- R6: The head entry is offered when more than one entry is held, or its mask is all ones, or it has waited `HOLD` cycles without being offered, or (with `FORWARD`=0) a read is pending. Once offered, it stays offered until taken.
- R7: An entry being offered accepts no merges. A store to its block allocates a new entry.
- R8: With `FORWARD`=1, a read returns `rd_hit`=1 and the newest buffered value of the word when any entry holds that word with its mask bit set. Otherwise `rd_hit`=0 and `rd_data`=0. `rd_stall` stays 0.
- R9: With `FORWARD`=1, a store accepted in the same cycle as a read of the same word supplies the read data.
- R10: With `FORWARD`=0, `rd_hit` is always 0, and `rd_stall` is 1 while a read is pending and the buffer is non-empty or a store is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store word |
| rd_req | input | 1 | Read-miss lookup request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_hit | output | 1 | Word found in buffer (forwarding mode) |
| rd_data | output | DATA_W | Forwarded word, zero on miss |
| rd_stall | output | 1 | Read must wait (stall mode) |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_addr | output | ADDR_W | Block byte address of the offered entry |
| mem_mask | output | WORDS | Valid word mask of the offered entry |
| mem_data | output | WORDS*DATA_W | Block data, word w in lane w |

## Verification
The assertions hold without any promise from the store side. A store may be withdrawn before it is accepted, and the properties still hold. The hold-steady property on the memory side assumes that an offer counts as taken only in a cycle where `mem_ready` is high. The bench's memory model raises and lowers `mem_ready` freely, including while nothing is offered.

Stimulus addresses stay within a few blocks, so merges, locked-head allocations and full-buffer back-pressure all occur often. The bench drives both modes from the same input sequence.

// File: rtl/wbm_pkg.sv
// Shared types for the merging write buffer.
// Assumes nothing beyond the standard types.
package wbm_pkg;
    // Offer state of the head entry toward memory.
    typedef enum logic {
        DR_HOLD  = 1'b0,   // head still open to merges
        DR_OFFER = 1'b1    // head offered and locked until taken
    } drain_e;
endpackage

// File: rtl/wbm_drain_ctrl.sv
// Queue bookkeeping and drain policy of the write buffer.
// Tracks head, tail and occupancy. Decides when the head entry is offered
// to memory. Assumes push is never asserted while full.
module wbm_drain_ctrl
    import wbm_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int HOLD    = 8,
    parameter int FORWARD = 1,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int AGE_W  = $clog2(HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             head_full,
    input  logic             rd_req,
    input  logic             mem_ready,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             empty,
    output logic             full,
    output logic             offer,
    output logic             pop
);
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic [AGE_W-1:0] age_q;
    drain_e           drn_q;
    logic             want;

    // Wrap-around increment of a queue pointer.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Drain decision for the head entry.
    always_comb begin
        want = (drn_q == DR_OFFER) || (cnt_q > CNT_W'(1)) || head_full ||
               (age_q == AGE_W'(HOLD)) || ((FORWARD == 0) && rd_req);
        offer = (cnt_q != '0) && want;
        pop   = offer && mem_ready;
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= nxt(tail_q);
            if (pop)  head_q <= nxt(head_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Wait counter and offer lock of the head entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
            drn_q <= DR_HOLD;
        end else if (pop) begin
            age_q <= '0;
            drn_q <= DR_HOLD;
        end else begin
            drn_q <= offer ? DR_OFFER : DR_HOLD;
            if ((cnt_q != '0) && !offer && (age_q != AGE_W'(HOLD)))
                age_q <= age_q + 1'b1;
        end
    end
endmodule

// File: rtl/wbm_entry_array.sv
// Entry storage of the write buffer: block tag, word mask and four words per entry.
// Performs the merge match and the newest-first read lookup.
// Assumes at most one open entry per block, which the top's allocation rule keeps.
module wbm_entry_array #(
    parameter int DEPTH  = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 64,
    parameter int BLK_W  = 27,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [PTR_W-1:0]  alloc_slot,
    input  logic              merge_en,
    input  logic [PTR_W-1:0]  merge_slot,
    input  logic              pop_en,
    input  logic [PTR_W-1:0]  head,
    input  logic              head_locked,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BLK_W-1:0]  rd_blk,
    input  logic [WIDX_W-1:0] rd_word,
    output logic              merge_hit,
    output logic [PTR_W-1:0]  merge_idx,
    output logic [BLK_W-1:0]  head_blk,
    output logic [WORDS-1:0]  head_mask,
    output logic [LINE_W-1:0] head_data,
    output logic              rd_found,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0]  vld_q;
    logic [BLK_W-1:0]  blk_q [DEPTH];
    logic [WORDS-1:0]  msk_q [DEPTH];
    logic [LINE_W-1:0] dat_q [DEPTH];
    logic [DEPTH-1:0]  match;
    logic [LINE_W-1:0] fresh_line;
    logic [WORDS-1:0]  fresh_mask;

    // Line image of a newly allocated entry: only the stored word is non-zero.
    always_comb begin
        fresh_line = '0;
        fresh_line[wr_word*DATA_W +: DATA_W] = wr_data;
        fresh_mask = WORDS'(1) << wr_word;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Open-entry tag compare; a locked head is excluded.
        assign match[i] = vld_q[i] && (blk_q[i] == wr_blk) &&
                          !(head_locked && (head == PTR_W'(i)));

        // Entry update: release on drain, fill on allocate, set a word on merge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                msk_q[i] <= '0;
            end else begin
                if (pop_en && (head == PTR_W'(i))) begin
                    vld_q[i] <= 1'b0;
                    msk_q[i] <= '0;
                end
                if (alloc_en && (alloc_slot == PTR_W'(i))) begin
                    vld_q[i] <= 1'b1;
                    blk_q[i] <= wr_blk;
                    msk_q[i] <= fresh_mask;
                    dat_q[i] <= fresh_line;
                end else if (merge_en && (merge_slot == PTR_W'(i))) begin
                    msk_q[i][wr_word] <= 1'b1;
                    dat_q[i][wr_word*DATA_W +: DATA_W] <= wr_data;
                end
            end
        end
    end

    // Priority encode of the (unique) merge target.
    always_comb begin
        merge_hit = |match;
        merge_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (match[i]) merge_idx = PTR_W'(i);
    end

    // Head entry fields toward memory.
    assign head_blk  = blk_q[head];
    assign head_mask = msk_q[head];
    assign head_data = dat_q[head];

    // Read lookup from oldest to newest so that the newest copy wins.
    always_comb begin : lookup
        int s;
        rd_found = 1'b0;
        rd_data  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            s = (int'(head) + k) % DEPTH;
            if (vld_q[s] && (blk_q[s] == rd_blk) && msk_q[s][rd_word]) begin
                rd_found = 1'b1;
                rd_data  = dat_q[s][rd_word*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/wbuf_merge_top.sv
// Merging write buffer between a write-through cache and a memory port.
// Decodes addresses, chooses between merge and allocation, and serves read misses
// by forwarding (FORWARD=1) or by stall (FORWARD=0).
// Assumes DEPTH >= 2, WORDS and DATA_W/8 are powers of two.
module wbuf_merge_top #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int WORDS   = 4,
    parameter int DEPTH   = 4,
    parameter int HOLD    = 8,
    parameter int FORWARD = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    rd_req,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_hit,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_stall,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORDS-1:0]        mem_mask,
    output logic [WORDS*DATA_W-1:0] mem_data
);
    localparam int OFF_W   = $clog2(DATA_W / 8);
    localparam int WIDX_W  = $clog2(WORDS);
    localparam int BLK_LSB = OFF_W + WIDX_W;
    localparam int BLK_W   = ADDR_W - BLK_LSB;
    localparam int PTR_W   = $clog2(DEPTH);

    logic [BLK_W-1:0]  st_blk, rd_blk, head_blk;
    logic [WIDX_W-1:0] st_word, rd_word;
    logic [PTR_W-1:0]  head, tail, merge_idx;
    logic              empty, full, offer, pop;
    logic              merge_hit, accept, merge_en, alloc_en;
    logic              arr_found;
    logic [DATA_W-1:0] arr_data;
    logic [WORDS-1:0]  head_mask;
    logic              head_full;
    logic              unused_lsbs;

    assign st_blk  = st_addr[ADDR_W-1:BLK_LSB];
    assign st_word = st_addr[BLK_LSB-1:OFF_W];
    assign rd_blk  = rd_addr[ADDR_W-1:BLK_LSB];
    assign rd_word = rd_addr[BLK_LSB-1:OFF_W];
    assign unused_lsbs = ^{st_addr[OFF_W-1:0], rd_addr[OFF_W-1:0]};

    // Store acceptance: merge into an open entry, else allocate if room.
    assign st_ready  = merge_hit || !full;
    assign accept    = st_valid && st_ready;
    assign merge_en  = accept && merge_hit;
    assign alloc_en  = accept && !merge_hit;
    assign head_full = &head_mask;

    wbm_drain_ctrl #(
        .DEPTH(DEPTH), .HOLD(HOLD), .FORWARD(FORWARD)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(alloc_en), .head_full(head_full),
        .rd_req(rd_req), .mem_ready(mem_ready), .head(head), .tail(tail),
        .empty(empty), .full(full), .offer(offer), .pop(pop)
    );

    wbm_entry_array #(
        .DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_slot(tail),
        .merge_en(merge_en), .merge_slot(merge_idx), .pop_en(pop),
        .head(head), .head_locked(offer), .wr_blk(st_blk), .wr_word(st_word),
        .wr_data(st_data), .rd_blk(rd_blk), .rd_word(rd_word),
        .merge_hit(merge_hit), .merge_idx(merge_idx), .head_blk(head_blk),
        .head_mask(head_mask), .head_data(mem_data), .rd_found(arr_found),
        .rd_data(arr_data)
    );

    // Memory-side view of the head entry.
    assign mem_valid = offer;
    assign mem_addr  = {head_blk, {BLK_LSB{1'b0}}};
    assign mem_mask  = head_mask;

    if (FORWARD != 0) begin : g_fwd
        logic bypass;
        assign bypass   = accept && (st_blk == rd_blk) && (st_word == rd_word);
        assign rd_stall = 1'b0;
        // Forwarded read result: same-cycle store first, then the buffer.
        always_comb begin
            rd_hit  = rd_req && (bypass || arr_found);
            rd_data = '0;
            if (rd_req) begin
                if (bypass)         rd_data = st_data;
                else if (arr_found) rd_data = arr_data;
            end
        end
    end else begin : g_stall
        logic unused_lookup;
        assign unused_lookup = ^{arr_found, arr_data};
        assign rd_hit   = 1'b0;
        assign rd_data  = '0;
        assign rd_stall = rd_req && (!empty || st_valid);
    end
endmodule

// File: rtl/wbm_checker.sv
// Port-level properties of the merging write buffer, bound to every instance.
// Assumes only the clock and synchronous active-low reset of the top.
module wbm_checker #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int WORDS   = 4,
    parameter int FORWARD = 1,
    localparam int OFF_W  = $clog2(DATA_W / 8)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic                    st_ready,
    input logic [ADDR_W-1:0]       st_addr,
    input logic [DATA_W-1:0]       st_data,
    input logic                    rd_req,
    input logic [ADDR_W-1:0]       rd_addr,
    input logic                    rd_hit,
    input logic [DATA_W-1:0]       rd_data,
    input logic                    rd_stall,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [WORDS-1:0]        mem_mask,
    input logic [WORDS*DATA_W-1:0] mem_data
);
    assert_offer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                    $stable(mem_mask) && $stable(mem_data));

    assert_mask_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_mask != '0));

    assert_full_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> mem_valid);

    assert_hit_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> rd_req);

    if (FORWARD != 0) begin : g_fwd
        assert_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_stall);
        assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            st_valid && st_ready && rd_req &&
            (st_addr[ADDR_W-1:OFF_W] == rd_addr[ADDR_W-1:OFF_W])
            |-> rd_hit && (rd_data == st_data));
    end else begin : g_stall
        assert_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_hit);
        assert_stall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stall |-> rd_req);
    end
endmodule

bind wbuf_merge_top wbm_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .FORWARD(FORWARD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_data(rd_data), .rd_stall(rd_stall),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_mask(mem_mask), .mem_data(mem_data)
);

// File: tb/sim_wbuf_merge_top.sv
// Bench: two instances (forwarding u0, stalling u1) share one stimulus.
// Each is compared on every cycle against a behavioural queue model.
module sim_wbuf_merge_top;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        sv = 1'b0, rr = 1'b0, mr = 1'b0;
    logic [31:0] sa = '0, ra = '0;
    logic [63:0] sd = '0;

    logic        rdy [2];
    logic        hit [2];
    logic        stl [2];
    logic        mv  [2];
    logic [63:0] rdd [2];
    logic [31:0] ma  [2];
    logic [3:0]  mm  [2];
    logic [255:0] md [2];

    wbuf_merge_top #(.HOLD(HOLD), .FORWARD(1)) u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(sv), .st_ready(rdy[0]),
        .st_addr(sa), .st_data(sd), .rd_req(rr), .rd_addr(ra),
        .rd_hit(hit[0]), .rd_data(rdd[0]), .rd_stall(stl[0]),
        .mem_valid(mv[0]), .mem_ready(mr), .mem_addr(ma[0]),
        .mem_mask(mm[0]), .mem_data(md[0]));

    wbuf_merge_top #(.HOLD(HOLD), .FORWARD(0)) u1 (
        .clk(clk), .rst_n(rst_n), .st_valid(sv), .st_ready(rdy[1]),
        .st_addr(sa), .st_data(sd), .rd_req(rr), .rd_addr(ra),
        .rd_hit(hit[1]), .rd_data(rdd[1]), .rd_stall(stl[1]),
        .mem_valid(mv[1]), .mem_ready(mr), .mem_addr(ma[1]),
        .mem_mask(mm[1]), .mem_data(md[1]));

    typedef struct packed {
        logic [26:0]  blk;
        logic [3:0]   msk;
        logic [255:0] d;
    } ent_t;

    ent_t mq [2][$];
    bit   lk [2];
    int   ag [2];

    int    vectors = 0, errors = 0;
    string tag = "R1";
    int    hs_cnt = 0;
    logic [3:0] hs_mask = '0;
    bit    done = 1'b0;

    task automatic chk(input string what, input logic [255:0] act, input logic [255:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL [%s] %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Compare one instance against the model, then advance the model one clock.
    task automatic eval(input int n);
        int cnt, midx;
        bit hf, fwd, emv, erdy, acc, ehit, estl;
        logic [63:0] erd;
        string pfx;
        pfx = (n == 0) ? "u0" : "u1";
        fwd = (n == 0);
        cnt = mq[n].size();
        hf  = (cnt > 0) && (mq[n][0].msk == 4'hF);
        emv = (cnt > 0) && (lk[n] || cnt > 1 || hf || ag[n] >= HOLD || (!fwd && rr));
        midx = -1;
        for (int i = 0; i < cnt; i++)
            if (mq[n][i].blk == sa[31:5] && !(i == 0 && emv)) midx = i;
        erdy = (midx >= 0) || (cnt < 4);
        acc  = sv && erdy;
        ehit = 1'b0;
        erd  = '0;
        if (fwd && rr) begin
            if (acc && sa[31:3] == ra[31:3]) begin
                ehit = 1'b1; erd = sd;
            end else begin
                for (int i = 0; i < cnt; i++)
                    if (mq[n][i].blk == ra[31:5] && mq[n][i].msk[ra[4:3]]) begin
                        ehit = 1'b1; erd = mq[n][i].d[ra[4:3]*64 +: 64];
                    end
            end
        end
        estl = !fwd && rr && (cnt != 0 || sv);
        chk({pfx, " R4 st_ready"}, 256'(rdy[n]), 256'(erdy));
        chk({pfx, " R6 mem_valid"}, 256'(mv[n]), 256'(emv));
        if (emv) begin
            chk({pfx, " R5 mem_addr"}, 256'(ma[n]), 256'({mq[n][0].blk, 5'b0}));
            chk({pfx, " R5 mem_mask"}, 256'(mm[n]), 256'(mq[n][0].msk));
            chk({pfx, " R5 mem_data"}, md[n], mq[n][0].d);
        end
        chk({pfx, " R8 rd_hit"}, 256'(hit[n]), 256'(ehit));
        chk({pfx, " R8 rd_data"}, 256'(rdd[n]), 256'(erd));
        chk({pfx, " R10 rd_stall"}, 256'(stl[n]), 256'(estl));
        if (n == 0 && mv[0] && mr) begin
            hs_cnt++; hs_mask = mm[0];
        end
        // model update
        if (acc) begin
            if (midx >= 0) begin
                mq[n][midx].msk[sa[4:3]] = 1'b1;
                mq[n][midx].d[sa[4:3]*64 +: 64] = sd;
            end else begin
                ent_t e;
                e.blk = sa[31:5];
                e.msk = 4'b0001 << sa[4:3];
                e.d   = '0;
                e.d[sa[4:3]*64 +: 64] = sd;
                mq[n].push_back(e);
            end
        end
        if (emv && mr) begin
            void'(mq[n].pop_front());
            lk[n] = 1'b0;
            ag[n] = 0;
        end else begin
            lk[n] = emv;
            if (cnt > 0 && !emv && ag[n] < HOLD) ag[n]++;
        end
    endtask

    task automatic step();
        @(negedge clk);
        eval(0);
        eval(1);
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic v, input logic [31:0] a, input logic [63:0] d,
                         input logic r, input logic [31:0] raddr, input logic m);
        sv = v; sa = a; sd = d; rr = r; ra = raddr; mr = m;
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL [watchdog] run did not finish act=hung exp=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 2; n++) begin lk[n] = 0; ag[n] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle state after reset
        tag = "R1";
        @(negedge clk);
        chk("R1 u0 st_ready", 256'(rdy[0]), 256'(1));
        chk("R1 u0 mem_valid", 256'(mv[0]), 256'(0));
        chk("R1 u1 mem_valid", 256'(mv[1]), 256'(0));
        chk("R1 u0 rd_hit", 256'(hit[0]), 256'(0));
        chk("R1 u1 rd_stall", 256'(stl[1]), 256'(0));
        @(posedge clk); #1;

        // R2: four stores to one block merge into a single transaction
        tag = "R2";
        hs_cnt = 0;
        drive(1, 32'd100, 64'hA0, 0, 0, 0);
        drive(1, 32'd108, 64'hA1, 0, 0, 0);
        drive(1, 32'd116, 64'hA2, 1, 32'd100, 0);
        drive(1, 32'd124, 64'hA3, 0, 0, 0);
        repeat (3) drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 32'd120, 1);
        repeat (2) drive(0, 0, 0, 0, 0, 1);
        chk("R2 single merged drain count", 256'(hs_cnt), 256'(1));
        chk("R2 merged mask", 256'(hs_mask), 256'(4'hF));

        // R3/R6: lone partial entry waits HOLD cycles, then drains
        tag = "R3";
        drive(1, 32'h0000_0208, 64'h55, 0, 0, 1);
        repeat (HOLD + 3) drive(0, 0, 0, 0, 0, 1);
        tag = "R6";
        drive(1, 32'h0000_0300, 64'h66, 0, 0, 0);
        repeat (HOLD + 2) drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1);

        // R4: fill four entries, fifth distinct block is held off
        tag = "R4";
        for (int b = 0; b < 5; b++)
            drive(1, 32'h1000 + 32'(b) * 32'h40, 64'(b + 1), 0, 0, 0);
        repeat (2) drive(1, 32'h1000 + 32'h100, 64'h5, 0, 0, 0);
        repeat (8) drive(0, 0, 0, 0, 0, 1);

        // R7: store to an offered head's block takes a new entry
        tag = "R7";
        drive(1, 32'h400, 64'h70, 0, 0, 0);
        drive(1, 32'h800, 64'h80, 0, 0, 0);
        drive(1, 32'h408, 64'h71, 1, 32'h400, 0);
        drive(1, 32'h400, 64'h72, 1, 32'h408, 0);
        tag = "R8";
        drive(0, 0, 0, 1, 32'h400, 0);
        drive(0, 0, 0, 1, 32'h410, 0);
        drive(0, 0, 0, 1, 32'h800, 1);
        tag = "R9";
        drive(1, 32'h418, 64'h99, 1, 32'h418, 0);
        drive(1, 32'h800, 64'h9A, 1, 32'h800, 0);
        repeat (6) drive(0, 0, 0, 0, 0, 1);

        // R10: stall mode read with empty buffer, then with pending store
        tag = "R10";
        drive(0, 0, 0, 1, 32'h40, 0);
        drive(1, 32'h40, 64'h1, 1, 32'h40, 0);
        drive(0, 0, 0, 1, 32'h40, 0);
        drive(0, 0, 0, 1, 32'h40, 1);
        drive(0, 0, 0, 0, 0, 1);

        // Mixed random traffic over a few blocks
        tag = "RND";
        for (int c = 0; c < 3000; c++) begin
            logic [31:0] a1, a2;
            a1 = {25'd0, 2'($urandom_range(0, 3)) , 2'($urandom_range(0, 3)), 3'($urandom)} << 0;
            a1 = {23'd0, 4'($urandom_range(0, 5)), 2'($urandom), 3'd0};
            a2 = {23'd0, 4'($urandom_range(0, 5)), 2'($urandom), 3'd0};
            drive(1'($urandom_range(0, 99) < 55), a1, {$urandom, $urandom},
                  1'($urandom_range(0, 99) < 40), a2,
                  1'($urandom_range(0, 99) < 35));
        end
        repeat (20) drive(0, 0, 0, 0, 0, 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule